// File: doc/BRIEF.md
# Multi-queue FIFO buffer with head and tail caches

This block holds several independent word FIFOs in a two-level store. Each queue owns a small fast tail cache that takes incoming words and a small fast head cache that feeds outgoing words. The middle of each queue lives in a slow block-wide bulk memory. Each queue has a ring region in that memory with its own block write and read pointers. Bulk memory moves only whole blocks of `BLK` words, so consecutive packets share blocks end to end and no short packet leaves a block half used. Each queue region is accessed strictly in FIFO order, so no segment lists are needed.

A queue moves one block from its tail cache to its bulk region once the tail holds a full block. It fetches a block back into its head cache ahead of demand once the head holds one block or less. When neither cache level nor bulk memory has anything older than the tail contents, reads are served directly from the tail cache. This keeps a lightly loaded queue fast and keeps order intact. Per-queue bulk requests share one memory port through a round-robin arbiter, with one block transfer per grant. The bulk read data returns `LAT` cycles after issue.

Top module: `qcache_buffer`

## Requirements
- R1: After reset, every `rd_avail` bit and every `in_full` bit is low, and `out_valid` is low.
- R2: Words read from queue q come out in exactly the order they were written to queue q, independently of traffic on the other queues.
- R3: A read with `rd_en` high to a queue whose `rd_avail` bit is high returns the oldest word on `out_data` with `out_valid` high in the next cycle. A read to a queue whose bit is low is ignored: `out_valid` is low in the next cycle and no word is consumed.
- R4: A word written to a queue that holds nothing makes that queue's `rd_avail` bit high in the next cycle, through the tail-cache bypass.
- R5: Bulk memory is written only with a whole block of `BLK` words taken from a tail cache that holds at least `BLK` words. A queue's bulk region never holds more than `NB` blocks.
- R6: At most one bulk block transfer is granted per cycle, in round-robin order among requesting queues. Within one queue, a head refill takes precedence over a tail flush.
- R7: A head refill is issued only when the queue's bulk region is not empty, no refill for that queue is in flight, and its head cache holds at most `BLK` words. The head cache never holds more than 2*`BLK` words.
- R8: With no reads, a queue accepts exactly 2*`BLK` + `NB`*`BLK` + 2*`BLK` words (32 at default parameters). Then its `in_full` bit is high. It is high whenever the tail cache holds 2*`BLK` words, and a write to a full queue is dropped.
- R9: A queue's `rd_avail` bit is high only while the queue holds at least one word. After all its words are read, the bit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write one word into queue `in_qid` |
| in_qid | input | $clog2(NQ) | Queue selected for the write |
| in_data | input | W | Word to write |
| in_full | output | NQ | Per-queue back-pressure; a write to a queue with its bit set is dropped |
| rd_en | input | 1 | Read one word from queue `rd_qid` |
| rd_qid | input | $clog2(NQ) | Queue selected for the read |
| rd_avail | output | NQ | Per-queue flag: a word can be read this cycle |
| out_valid | output | 1 | `out_data` carries a word read in the previous cycle |
| out_data | output | W | Word read |

## Verification
The assertions assume the caller reads only through `rd_en` and `rd_qid`, and that a write to a full queue leaves the cache levels bounded. The bench therefore never has to avoid full queues, and it deliberately writes to full queues and reads from unavailable ones. The parameters must be powers of two for the pointer wrap, and the bench uses the defaults. The stimulus mixes random writes and reads across all four queues so that refills and flushes of different queues contend for the bulk port. A directed fill and drain of one queue drives the tail, bulk and head levels to their limits.

// File: rtl/qcache_pkg.sv
// Shared definitions for the head/tail cached queue buffer.
package qcache_pkg;
    // Kind of bulk-memory block transfer a queue lane asks for.
    typedef enum logic [1:0] {
        XFER_NONE  = 2'd0,
        XFER_FLUSH = 2'd1,
        XFER_FILL  = 2'd2
    } xfer_e;
endpackage

// File: rtl/qcache_rr_arb.sv
// Round-robin arbiter. It grants at most one requester per cycle, starting
// the search at the requester after the last one granted.
// Assumes: requests are level signals sampled every cycle.
module qcache_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    int            gidx;

    // Purpose: pick the first requester at or after the pointer.
    always_comb begin
        gnt  = '0;
        gidx = -1;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= N) idx = idx - N;
            if (gidx < 0 && req[idx]) begin
                gnt[idx] = 1'b1;
                gidx     = idx;
            end
        end
    end

    // Purpose: move the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (gidx >= 0) begin
            ptr <= IW'((gidx + 1) % N);
        end
    end
endmodule

// File: rtl/qcache_bulk_store.sv
// Block-wide bulk memory model with one shared port and fixed read latency.
// A write stores a whole block at once. A read returns a whole block with
// its tag LAT cycles after issue.
// Assumes: LAT >= 1, and we and re are never high together.
module qcache_bulk_store #(
    parameter int DEPTH = 16,
    parameter int BW    = 32,
    parameter int TW    = 2,
    parameter int LAT   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    input  logic [TW-1:0] rtag,
    output logic          rvalid,
    output logic [BW-1:0] rdata,
    output logic [TW-1:0] otag
);
    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] pd  [LAT];
    logic [TW-1:0] pt  [LAT];
    logic [LAT-1:0] pv;

    // Purpose: store a block and run the read data pipeline.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        pd[0] <= mem[addr];
        pt[0] <= rtag;
        for (int s = 1; s < LAT; s++) begin
            pd[s] <= pd[s-1];
            pt[s] <= pt[s-1];
        end
    end

    // Purpose: track read-valid through the latency stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
        end else begin
            pv[0] <= re;
            for (int s = 1; s < LAT; s++) pv[s] <= pv[s-1];
        end
    end

    assign rvalid = pv[LAT-1];
    assign rdata  = pd[LAT-1];
    assign otag   = pt[LAT-1];
endmodule

// File: rtl/qcache_lane.sv
// One queue: a tail cache, a head cache and the ring pointers of its bulk
// region. It asks for a refill when the head is low, and for a flush when
// the tail holds a block. A read takes the head word, or the tail word when
// the head is empty.
// Assumes: BLK and NB are powers of two, rd_en is high only when the queue
// is readable, wr_en is never high while the tail is full, and gnt is high
// only when req is high.
module qcache_lane #(
    parameter int W   = 8,
    parameter int BLK = 4,
    parameter int NB  = 4,
    localparam int TDEP = 2 * BLK,
    localparam int TAW  = $clog2(TDEP),
    localparam int CW   = $clog2(TDEP + 1),
    localparam int PW   = (NB > 1) ? $clog2(NB) : 1,
    localparam int BCW  = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_word,
    output qcache_pkg::xfer_e xfer,
    input  logic             gnt,
    output logic [PW-1:0]    bptr,
    output logic [BLK*W-1:0] flush_blk,
    input  logic             fill_valid,
    input  logic [BLK*W-1:0] fill_blk,
    output logic [CW-1:0]    tlvl,
    output logic [CW-1:0]    hlvl,
    output logic [BCW-1:0]   blvl,
    output logic             busy
);
    import qcache_pkg::*;

    logic [W-1:0]   tmem [TDEP];
    logic [W-1:0]   hmem [TDEP];
    logic [TAW-1:0] twp, trp, hwp, hrp;
    logic [CW-1:0]  tcnt, hcnt;
    logic [BCW-1:0] bcnt;
    logic [PW-1:0]  bwp, brp;
    logic           inflight;
    logic           head_rd, tail_rd, want_fill, want_flush, do_fill, do_flush;

    // Purpose: choose the read source and the bulk request.
    always_comb begin
        head_rd    = rd_en && (hcnt != '0);
        tail_rd    = rd_en && (hcnt == '0);
        rd_word    = (hcnt != '0) ? hmem[hrp] : tmem[trp];
        want_fill  = (bcnt != '0) && !inflight && (hcnt <= CW'(BLK));
        want_flush = (tcnt >= CW'(BLK)) && (bcnt < BCW'(NB)) && !tail_rd;
        xfer       = want_fill ? XFER_FILL : (want_flush ? XFER_FLUSH : XFER_NONE);
        do_fill    = gnt && want_fill;
        do_flush   = gnt && !want_fill;
        bptr       = want_fill ? brp : bwp;
    end

    // Purpose: gather the oldest block of the tail cache for a flush.
    always_comb begin
        for (int i = 0; i < BLK; i++) begin
            logic [TAW-1:0] idx;
            idx = trp + TAW'(i);
            flush_blk[i*W +: W] = tmem[idx];
        end
    end

    // Purpose: cache storage writes (no reset needed on data).
    always_ff @(posedge clk) begin
        if (wr_en) tmem[twp] <= wr_data;
        if (fill_valid) begin
            for (int i = 0; i < BLK; i++) begin
                logic [TAW-1:0] idx;
                idx = hwp + TAW'(i);
                hmem[idx] <= fill_blk[i*W +: W];
            end
        end
    end

    // Purpose: pointers and levels of the tail cache, head cache and bulk ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            twp <= '0; trp <= '0; hwp <= '0; hrp <= '0;
            tcnt <= '0; hcnt <= '0; bcnt <= '0;
            bwp <= '0; brp <= '0; inflight <= 1'b0;
        end else begin
            twp  <= twp + TAW'(wr_en);
            trp  <= trp + TAW'(tail_rd) + (do_flush ? TAW'(BLK) : TAW'(0));
            tcnt <= tcnt + CW'(wr_en) - CW'(tail_rd) - (do_flush ? CW'(BLK) : CW'(0));
            hrp  <= hrp + TAW'(head_rd);
            hwp  <= hwp + (fill_valid ? TAW'(BLK) : TAW'(0));
            hcnt <= hcnt - CW'(head_rd) + (fill_valid ? CW'(BLK) : CW'(0));
            bcnt <= bcnt + BCW'(do_flush) - BCW'(do_fill);
            bwp  <= bwp + PW'(do_flush);
            brp  <= brp + PW'(do_fill);
            if (do_fill)         inflight <= 1'b1;
            else if (fill_valid) inflight <= 1'b0;
        end
    end

    assign tlvl = tcnt;
    assign hlvl = hcnt;
    assign blvl = bcnt;
    assign busy = inflight;
endmodule

// File: rtl/qcache_buffer.sv
// Top: NQ queue lanes sharing one block-wide bulk memory through a
// round-robin arbiter. It gates writes by back-pressure and reads by
// availability, and registers the read word.
// Assumes: NQ, BLK and NB are powers of two, NQ >= 2.
module qcache_buffer #(
    parameter int NQ  = 4,
    parameter int W   = 8,
    parameter int BLK = 4,
    parameter int NB  = 4,
    parameter int LAT = 2,
    localparam int QW   = $clog2(NQ),
    localparam int TDEP = 2 * BLK,
    localparam int CW   = $clog2(TDEP + 1),
    localparam int PW   = (NB > 1) ? $clog2(NB) : 1,
    localparam int BCW  = $clog2(NB + 1),
    localparam int AW   = $clog2(NQ * NB),
    localparam int BW   = BLK * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [QW-1:0] in_qid,
    input  logic [W-1:0]  in_data,
    output logic [NQ-1:0] in_full,
    input  logic          rd_en,
    input  logic [QW-1:0] rd_qid,
    output logic [NQ-1:0] rd_avail,
    output logic          out_valid,
    output logic [W-1:0]  out_data
);
    import qcache_pkg::*;

    logic [W-1:0]    lane_word  [NQ];
    logic [BW-1:0]   lane_flush [NQ];
    logic [PW-1:0]   lane_bptr  [NQ];
    xfer_e           lane_xfer  [NQ];
    logic [NQ-1:0]   req, gnt, wgnt, rgnt, busy;
    logic [NQ*CW-1:0]  tlvl_flat, hlvl_flat;
    logic [NQ*BCW-1:0] blvl_flat;
    logic            wr_ok, rd_ok;
    logic [AW-1:0]   bulk_addr;
    logic [BW-1:0]   bulk_wdata, bulk_rdata;
    logic [QW-1:0]   bulk_tag, fill_tag;
    logic            fill_valid;

    assign wr_ok = in_valid && !in_full[in_qid];
    assign rd_ok = rd_en && rd_avail[rd_qid];

    for (genvar q = 0; q < NQ; q++) begin : g_lane
        logic [CW-1:0]  tl, hl;
        logic [BCW-1:0] bl;

        qcache_lane #(.W(W), .BLK(BLK), .NB(NB)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_ok && (in_qid == QW'(q))),
            .wr_data    (in_data),
            .rd_en      (rd_ok && (rd_qid == QW'(q))),
            .rd_word    (lane_word[q]),
            .xfer       (lane_xfer[q]),
            .gnt        (gnt[q]),
            .bptr       (lane_bptr[q]),
            .flush_blk  (lane_flush[q]),
            .fill_valid (fill_valid && (fill_tag == QW'(q))),
            .fill_blk   (bulk_rdata),
            .tlvl       (tl),
            .hlvl       (hl),
            .blvl       (bl),
            .busy       (busy[q])
        );

        // Purpose: per-queue flags derived from the lane levels.
        always_comb begin
            req[q]      = (lane_xfer[q] != XFER_NONE);
            rgnt[q]     = gnt[q] && (lane_xfer[q] == XFER_FILL);
            wgnt[q]     = gnt[q] && (lane_xfer[q] == XFER_FLUSH);
            in_full[q]  = (tl == CW'(TDEP));
            rd_avail[q] = (hl != '0) || ((bl == '0) && !busy[q] && (tl != '0));
        end

        assign tlvl_flat[q*CW +: CW]   = tl;
        assign hlvl_flat[q*CW +: CW]   = hl;
        assign blvl_flat[q*BCW +: BCW] = bl;
    end

    qcache_rr_arb #(.N(NQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    // Purpose: route the granted lane onto the bulk memory port.
    always_comb begin
        bulk_addr  = '0;
        bulk_wdata = '0;
        bulk_tag   = '0;
        for (int q = 0; q < NQ; q++) begin
            if (gnt[q]) begin
                bulk_addr  = AW'(q * NB + int'(lane_bptr[q]));
                bulk_wdata = lane_flush[q];
                bulk_tag   = QW'(q);
            end
        end
    end

    qcache_bulk_store #(.DEPTH(NQ * NB), .BW(BW), .TW(QW), .LAT(LAT)) u_bulk (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (|wgnt),
        .re     (|rgnt),
        .addr   (bulk_addr),
        .wdata  (bulk_wdata),
        .rtag   (bulk_tag),
        .rvalid (fill_valid),
        .rdata  (bulk_rdata),
        .otag   (fill_tag)
    );

    // Purpose: register the word read this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_ok;
            if (rd_ok) out_data <= lane_word[rd_qid];
        end
    end
endmodule

// File: rtl/qcache_checker.sv
// Assertions for qcache_buffer, bound to it below.
module qcache_checker #(
    parameter int NQ  = 4,
    parameter int BLK = 4,
    parameter int NB  = 4,
    parameter int QW  = 2,
    parameter int CW  = 4,
    parameter int BCW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NQ-1:0]     gnt,
    input logic [NQ-1:0]     wgnt,
    input logic [NQ-1:0]     rgnt,
    input logic [NQ*CW-1:0]  tlvl,
    input logic [NQ*CW-1:0]  hlvl,
    input logic [NQ*BCW-1:0] blvl,
    input logic              rd_en,
    input logic [QW-1:0]     rd_qid,
    input logic [NQ-1:0]     rd_avail,
    input logic              out_valid
);
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R6

    AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_avail[rd_qid]) |=> out_valid); // R3

    AST_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_avail[rd_qid]) |=> !out_valid); // R3

    for (genvar q = 0; q < NQ; q++) begin : g_q
        AST_FLUSH_WHOLE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            wgnt[q] |-> (tlvl[q*CW +: CW] >= CW'(BLK))); // R5

        AST_BULK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            blvl[q*BCW +: BCW] <= BCW'(NB)); // R5

        AST_REFILL_FROM_BULK: assert property (@(posedge clk) disable iff (!rst_n)
            rgnt[q] |-> (blvl[q*BCW +: BCW] != '0)); // R7

        AST_HEAD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            hlvl[q*CW +: CW] <= CW'(2 * BLK)); // R7

        AST_TAIL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            tlvl[q*CW +: CW] <= CW'(2 * BLK)); // R8
    end
endmodule

bind qcache_buffer qcache_checker #(
    .NQ(NQ), .BLK(BLK), .NB(NB), .QW(QW), .CW(CW), .BCW(BCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (gnt),
    .wgnt      (wgnt),
    .rgnt      (rgnt),
    .tlvl      (tlvl_flat),
    .hlvl      (hlvl_flat),
    .blvl      (blvl_flat),
    .rd_en     (rd_en),
    .rd_qid    (rd_qid),
    .rd_avail  (rd_avail),
    .out_valid (out_valid)
);

// File: tb/test_qcache_buffer.sv
// Bench for qcache_buffer: directed corner cases plus seeded random traffic,
// checked against a per-queue reference FIFO model.
module test_qcache_buffer;
    localparam int NQ  = 4;
    localparam int W   = 8;
    localparam int BLK = 4;
    localparam int NB  = 4;
    localparam int LAT = 2;
    localparam int QW  = $clog2(NQ);
    localparam int CAP = 2 * BLK + NB * BLK + 2 * BLK;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [QW-1:0] in_qid = '0;
    logic [W-1:0]  in_data = '0;
    logic [NQ-1:0] in_full;
    logic          rd_en = 1'b0;
    logic [QW-1:0] rd_qid = '0;
    logic [NQ-1:0] rd_avail;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    bit last_wacc;
    logic [W-1:0] model [NQ][$];

    always #2 clk = ~clk;

    qcache_buffer #(.NQ(NQ), .W(W), .BLK(BLK), .NB(NB), .LAT(LAT)) i_qcache_buffer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_qid(in_qid), .in_data(in_data), .in_full(in_full),
        .rd_en(rd_en), .rd_qid(rd_qid), .rd_avail(rd_avail),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit model_has(input int q);
        return model[q].size() > 0;
    endfunction

    // One cycle: called just after a falling edge; drives, updates the model,
    // waits for the next falling edge and checks the registered output.
    task automatic step(input bit wv, input int wq, input logic [W-1:0] wd,
                        input bit rv, input int rq);
        bit racc;
        logic [W-1:0] exp_d;
        exp_d = '0;
        for (int q = 0; q < NQ; q++)
            if (rd_avail[q]) check(model_has(q), "R9 avail implies data", 0, 1);
        in_valid = wv; in_qid = QW'(wq); in_data = wd;
        rd_en = rv; rd_qid = QW'(rq);
        last_wacc = wv && !in_full[wq];
        racc = rv && rd_avail[rq];
        if (racc) exp_d = model[rq].pop_front();
        if (last_wacc) model[wq].push_back(wd);
        @(negedge clk);
        in_valid = 1'b0; rd_en = 1'b0;
        check(out_valid == racc, racc ? "R3 read returns word" : "R3 read ignored",
              int'(out_valid), int'(racc));
        if (racc) check(out_data == exp_d, "R2 order", int'(out_data), int'(exp_d));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin : main
        int acc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_avail == '0, "R1 rd_avail", int'(rd_avail), 0);
        check(in_full == '0, "R1 in_full", int'(in_full), 0);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

        // R3 read of an empty queue is ignored
        step(0, 0, '0, 1, 2);

        // R4 bypass: one word into empty queue 1 is readable next cycle
        step(1, 1, 8'hA5, 0, 0);
        check(rd_avail[1] == 1'b1, "R4 bypass avail", int'(rd_avail[1]), 1);
        check(rd_avail[0] == 1'b0, "R9 other queue empty", int'(rd_avail[0]), 0);
        step(0, 0, '0, 1, 1);
        check(rd_avail[1] == 1'b0, "R9 drained", int'(rd_avail[1]), 0);

        // R8 capacity fill of queue 0 (relies on R5 and R7 block rules)
        acc = 0;
        for (int i = 0; i < 3 * CAP; i++) begin
            step(1, 0, W'(i + 1), 0, 0);
            if (last_wacc) acc++;
        end
        check(acc == CAP, "R8 R5 R7 capacity", acc, CAP);
        check(in_full[0] == 1'b1, "R8 full flag", int'(in_full[0]), 1);
        step(1, 0, 8'hEE, 0, 0);
        check(last_wacc == 1'b0, "R8 write dropped when full", int'(last_wacc), 0);

        // Drain queue 0 fully, checking order (R2)
        for (int i = 0; i < 10 * CAP && model_has(0); i++) step(0, 0, '0, 1, 0);
        check(model[0].size() == 0, "R8 all words drained", model[0].size(), 0);
        repeat (4) step(0, 0, '0, 0, 0);
        check(rd_avail[0] == 1'b0, "R9 empty after drain", int'(rd_avail[0]), 0);
        step(0, 0, '0, 1, 0);

        // Random mixed traffic: contention for bulk port (R6), order (R2)
        for (int i = 0; i < 4000; i++) begin
            int wq, rq;
            bit wv, rv;
            wq = int'($urandom_range(NQ - 1));
            rq = int'($urandom_range(NQ - 1));
            wv = ($urandom_range(99) < 65);
            rv = ($urandom_range(99) < 55);
            step(wv, wq, W'($urandom), rv, rq);
        end

        // Final drain of every queue (R2 R6)
        for (int q = 0; q < NQ; q++)
            for (int i = 0; i < 20 * CAP && model_has(q); i++) step(0, 0, '0, 1, q);
        for (int q = 0; q < NQ; q++)
            check(model[q].size() == 0, "R2 final drain", model[q].size(), 0);
        repeat (4) step(0, 0, '0, 0, 0);
        check(rd_avail == '0, "R9 all empty", int'(rd_avail), 0);
        check(in_full == '0, "R8 not full when empty", int'(in_full), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule